// File: doc/BRIEF.md
# Command-Word VGA Line Serializer

This block produces the horizontal part of a VGA scanline. It does not count fixed porch and sync widths. Instead it reads a stream of 32-bit command words from a valid/ready source, usually a FIFO fed by a DMA engine. Each word names one action: hold the horizontal sync pin active, paint a run of one colour, raise a one-cycle line interrupt, or send a number of pixels. Each action lasts a known number of clocks. Words are taken back to back, so the sum of the encoded counts and the fixed per-action overheads sets the exact length of each line segment.

An output command is followed in the stream by pixel data words. Each data word carries four 8-bit pixels. Every pixel is held on the colour bus for a programmable number of clocks. The sync pin polarity is chosen by a static input. Vertical timing, memory fetch and building the command list are left to surrounding logic.

Top module: `vga_cmd_serializer`

## Requirements
- R1: The operation code sits in bits 31:27 of a command word: 0 is a colour run, 1 is sync, 2 is interrupt and 3 is pixel output. Any other code acts as a colour run of colour 0 that uses the run length in bits 23:8.
- R2: A sync word with count k in bits 15:0 holds HSYNC active for k+3 clocks with colour 0 and no interrupt.
- R3: A colour-run word with run length k in bits 23:8 and colour c in bits 7:0 drives c for k+4 clocks with HSYNC inactive.
- R4: An interrupt word lasts 9 clocks with colour 0, and `irq_o` is high in the first of those clocks only.
- R5: An output word with count k in bits 15:0 gives one lead clock of colour 0 and then k+2 pixels. Each pixel is held for `cpp_m2_i`+2 clocks.
- R6: Each data word supplies four pixels: bits 7:0 first, then 15:8, 23:16 and 31:24. A fresh data word is taken every fourth pixel. Unused bytes of the final data word of a run are dropped, and the next word taken is a command.
- R7: With `pos_sync_i` high, HSYNC is 1 while active and 0 otherwise. With it low, the pin is inverted.
- R8: A command accepted in a cycle takes effect in the next cycle. With words always available, commands follow each other with no gap cycle.
- R9: When no command word is offered at a command boundary, the block idles with colour 0, HSYNC inactive and `cmd_ready_o` high. The next command starts the cycle after it is accepted.
- R10: When no data word is offered at a pixel-word boundary, that group of up to four pixels shows colour 0. No word is consumed for the group, and pixel timing runs on unchanged.
- R11: After reset the block is idle: `cmd_ready_o` high, colour 0, HSYNC inactive, `irq_o` low.
- R12: When the final pixel of a run is also the fourth pixel of its data word, the word taken at that boundary is treated as a command, not as pixel data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_data_i | input | WORD_W | Command or pixel data word |
| cmd_valid_i | input | 1 | Word on `cmd_data_i` is valid |
| cmd_ready_o | output | 1 | Block takes the word this cycle if valid |
| cpp_m2_i | input | WAIT_W | Clocks per pixel minus 2 |
| pos_sync_i | input | 1 | 1 = HSYNC active high |
| colour_o | output | PIX_W | Colour bus |
| hsync_o | output | 1 | Horizontal sync pin |
| irq_o | output | 1 | One-cycle line interrupt |

## Verification
Two events can land on the same ready cycle: the end of a pixel run and the refill of pixel data every fourth pixel. The bench provokes this with a run of exactly eight pixels, whose last pixel is byte 3 of its word. It then checks that the following word acts as a colour run and is not shown as pixels. A run of six pixels covers the opposite case, where spare bytes must be dropped. A missing word at a pixel boundary is also tested against a missing word at a command boundary. Each cycle of colour, sync and interrupt is compared with a trace built from the word list.

// File: rtl/vls_pkg.sv
// Shared encodings and timing overheads for the command-word line serializer.
// Assumes 32-bit command words with the operation code in the top five bits.
package vls_pkg;
    localparam int OPC_W      = 5;
    localparam int SYNC_OVH   = 3;   // clocks added to a sync count
    localparam int BLANK_OVH  = 4;   // clocks added to a run length
    localparam int IRQ_CYCLES = 9;   // fixed length of an interrupt command
    localparam int PIX_OVH    = 2;   // pixels added to an output count

    localparam logic [OPC_W-1:0] OP_RUN  = 5'd0;
    localparam logic [OPC_W-1:0] OP_SYNC = 5'd1;
    localparam logic [OPC_W-1:0] OP_IRQ  = 5'd2;
    localparam logic [OPC_W-1:0] OP_OUT  = 5'd3;

    typedef enum logic [2:0] {
        M_IDLE,
        M_SYNC,
        M_RUN,
        M_IRQ,
        M_LEAD,
        M_PIX
    } mode_t;
endpackage

// File: rtl/vls_cmd_decode.sv
// Combinational decoder: turns one command word into the mode to enter, the
// countdown value for timed modes (length minus one), the run colour and the
// pixel count of an output command. Unknown codes become colour-0 runs.
module vls_cmd_decode
    import vls_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RUN_W  = 16,
    parameter int PIX_W  = 8
) (
    input  logic [WORD_W-1:0] word_i,
    output mode_t             mode_o,
    output logic [RUN_W+1:0]  load_o,
    output logic [PIX_W-1:0]  colour_o,
    output logic [RUN_W:0]    pixels_o
);
    localparam int RUN_LSB = PIX_W;
    localparam int OPC_LSB = WORD_W - OPC_W;
    localparam logic [RUN_W+1:0] K_SYNC = (RUN_W+2)'(SYNC_OVH - 1);
    localparam logic [RUN_W+1:0] K_RUN  = (RUN_W+2)'(BLANK_OVH - 1);
    localparam logic [RUN_W+1:0] K_IRQ  = (RUN_W+2)'(IRQ_CYCLES - 1);
    localparam logic [RUN_W:0]   K_PIX  = (RUN_W+1)'(PIX_OVH);

    logic [OPC_W-1:0] opc;
    logic [RUN_W-1:0] count;
    logic [RUN_W-1:0] run_len;

    assign opc     = word_i[WORD_W-1 -: OPC_W];
    assign count   = word_i[RUN_W-1:0];
    assign run_len = word_i[RUN_LSB +: RUN_W];

    generate
        if (OPC_LSB > RUN_LSB + RUN_W) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^word_i[OPC_LSB-1:RUN_LSB+RUN_W];
        end
    endgenerate

    // Select mode, countdown and colour from the operation code.
    always_comb begin
        mode_o   = M_RUN;
        load_o   = {2'b00, run_len} + K_RUN;
        colour_o = '0;
        pixels_o = {1'b0, count} + K_PIX;
        case (opc)
            OP_RUN:  colour_o = word_i[PIX_W-1:0];
            OP_SYNC: begin
                mode_o = M_SYNC;
                load_o = {2'b00, count} + K_SYNC;
            end
            OP_IRQ: begin
                mode_o = M_IRQ;
                load_o = K_IRQ;
            end
            OP_OUT: begin
                mode_o = M_LEAD;
                load_o = '0;
            end
            default: colour_o = '0;
        endcase
    end
endmodule

// File: rtl/vls_pixel_lane.sv
// Pixel unpacker: holds one data word, presents its low byte as the current
// pixel and shifts one byte down per pixel. A refill without data marks the
// group dark so it shows colour 0. Assumes WORD_W is a multiple of PIX_W.
module vls_pixel_lane #(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refill_i,
    input  logic              refill_ok_i,
    input  logic              advance_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [PIX_W-1:0]  pixel_o,
    output logic              last_o
);
    localparam int LANES = WORD_W / PIX_W;
    localparam int IDX_W = $clog2(LANES);

    logic [WORD_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              dark_q;

    // Load a new word or step to the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
            dark_q  <= 1'b1;
        end else if (refill_i) begin
            idx_q  <= '0;
            dark_q <= !refill_ok_i;
            if (refill_ok_i) shreg_q <= word_i;
        end else if (advance_i) begin
            shreg_q <= shreg_q >> PIX_W;
            idx_q   <= idx_q + IDX_W'(1);
        end
    end

    assign pixel_o = dark_q ? '0 : shreg_q[PIX_W-1:0];
    assign last_o  = (idx_q == IDX_W'(LANES - 1));

    a_r6_refill_first: assert property (@(posedge clk) disable iff (!rst_n)
        refill_i |=> (idx_q == '0));
    a_r10_dark_group: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_i && !refill_ok_i) |=> (pixel_o == '0));
endmodule

// File: rtl/vls_pin_drive.sv
// Output stage: picks the colour for the current mode, applies the sync
// polarity and gates the interrupt to the first interrupt clock.
module vls_pin_drive
    import vls_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  mode_t            mode_i,
    input  logic [PIX_W-1:0] run_colour_i,
    input  logic [PIX_W-1:0] pixel_i,
    input  logic             irq_first_i,
    input  logic             pos_sync_i,
    output logic [PIX_W-1:0] colour_o,
    output logic             hsync_o,
    output logic             irq_o
);
    logic sync_act;

    // Colour mux: runs and pixels drive data, all other modes are black.
    always_comb begin
        if (mode_i == M_RUN)      colour_o = run_colour_i;
        else if (mode_i == M_PIX) colour_o = pixel_i;
        else                      colour_o = '0;
    end

    assign sync_act = (mode_i == M_SYNC);
    assign hsync_o  = pos_sync_i ? sync_act : !sync_act;
    assign irq_o    = (mode_i == M_IRQ) && irq_first_i;
endmodule

// File: rtl/vga_cmd_serializer.sv
// Top of the command-word line serializer. A sequencer walks through timed
// modes (sync, colour run, interrupt) with a countdown and through output runs
// with a per-pixel hold timer and a pixel counter. cmd_ready_o depends only on
// state: it is high on command boundaries and on pixel-word refill slots.
// Assumes cpp_m2_i and pos_sync_i are static while a line is running.
module vga_cmd_serializer
    import vls_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 8,
    parameter int RUN_W  = 16,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cmd_data_i,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [WAIT_W-1:0] cpp_m2_i,
    input  logic              pos_sync_i,
    output logic [PIX_W-1:0]  colour_o,
    output logic              hsync_o,
    output logic              irq_o
);
    localparam logic [RUN_W+1:0] IRQ_FIRST = (RUN_W+2)'(IRQ_CYCLES - 1);
    localparam logic [RUN_W:0]   REM_ONE   = (RUN_W+1)'(1);

    mode_t            mode_q, dec_mode;
    logic [RUN_W+1:0] cnt_q, dec_load;
    logic [PIX_W-1:0] rcol_q, dec_col, pixel;
    logic [RUN_W:0]   rem_q, dec_pix;
    logic [WAIT_W:0]  hold_q, hold_load;
    logic             timed, pix_edge, rem_one, last_lane;
    logic             cmd_end, pix_slot, advance;

    vls_cmd_decode #(.WORD_W(WORD_W), .RUN_W(RUN_W), .PIX_W(PIX_W)) u_dec (
        .word_i   (cmd_data_i),
        .mode_o   (dec_mode),
        .load_o   (dec_load),
        .colour_o (dec_col),
        .pixels_o (dec_pix)
    );

    vls_pixel_lane #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .refill_i    (pix_slot),
        .refill_ok_i (cmd_valid_i),
        .advance_i   (advance),
        .word_i      (cmd_data_i),
        .pixel_o     (pixel),
        .last_o      (last_lane)
    );

    vls_pin_drive #(.PIX_W(PIX_W)) u_pins (
        .mode_i       (mode_q),
        .run_colour_i (rcol_q),
        .pixel_i      (pixel),
        .irq_first_i  (cnt_q == IRQ_FIRST),
        .pos_sync_i   (pos_sync_i),
        .colour_o     (colour_o),
        .hsync_o      (hsync_o),
        .irq_o        (irq_o)
    );

    assign hold_load = {1'b0, cpp_m2_i} + (WAIT_W+1)'(1);
    assign timed     = (mode_q == M_SYNC) || (mode_q == M_RUN) || (mode_q == M_IRQ);
    assign pix_edge  = (mode_q == M_PIX) && (hold_q == '0);
    assign rem_one   = (rem_q == REM_ONE);
    assign cmd_end   = (mode_q == M_IDLE) || (timed && cnt_q == '0) || (pix_edge && rem_one);
    assign pix_slot  = (mode_q == M_LEAD) || (pix_edge && !rem_one && last_lane);
    assign advance   = pix_edge && !rem_one && !last_lane;
    assign cmd_ready_o = cmd_end || pix_slot;

    // Sequencer: start a new command at a boundary, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_IDLE;
            cnt_q  <= '0;
            rcol_q <= '0;
            rem_q  <= '0;
            hold_q <= '0;
        end else if (cmd_end) begin
            if (cmd_valid_i) begin
                mode_q <= dec_mode;
                cnt_q  <= dec_load;
                rcol_q <= dec_col;
                rem_q  <= dec_pix;
            end else begin
                mode_q <= M_IDLE;
            end
        end else begin
            case (mode_q)
                M_SYNC, M_RUN, M_IRQ: cnt_q <= cnt_q - (RUN_W+2)'(1);
                M_LEAD: begin
                    mode_q <= M_PIX;
                    hold_q <= hold_load;
                end
                M_PIX: begin
                    if (hold_q == '0) begin
                        rem_q  <= rem_q - (RUN_W+1)'(1);
                        hold_q <= hold_load;
                    end else begin
                        hold_q <= hold_q - (WAIT_W+1)'(1);
                    end
                end
                default: mode_q <= M_IDLE;
            endcase
        end
    end

    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    a_r2_sync_black: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o == pos_sync_i) |-> (colour_o == '0));
    a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && cmd_valid_i) |=> (mode_q != M_IDLE));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_IDLE) |-> (colour_o == '0 && !irq_o && cmd_ready_o));
    a_r5_hold_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_PIX) |-> (hold_q <= hold_load));
    a_r12_run_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_edge && rem_one) |=> (mode_q != M_PIX));
endmodule

// File: tb/tb_vga_cmd_serializer.sv
module tb_vga_cmd_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int MAXE = 64;
    localparam int MAXT = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cpp_m2 = '0;
    logic        pos_sync = 1'b1;
    logic [7:0]  colour;
    logic        hsync, irq;

    int checks = 0;
    int failures = 0;

    logic [32:0] ent [MAXE];
    int          n_ent;
    logic [7:0]  e_col [MAXT];
    logic        e_hs  [MAXT];
    logic        e_irq [MAXT];
    int          ne;
    logic [7:0]  a_col [MAXT];
    logic        a_hs  [MAXT];
    logic        a_irq [MAXT];

    vga_cmd_serializer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_data_i  (cmd_data),
        .cmd_valid_i (cmd_valid),
        .cmd_ready_o (cmd_ready),
        .cpp_m2_i    (cpp_m2),
        .pos_sync_i  (pos_sync),
        .colour_o    (colour),
        .hsync_o     (hsync),
        .irq_o       (irq)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic logic [32:0] w_sync(int k);  return {1'b0, 5'd1, 27'(k)}; endfunction
    function automatic logic [32:0] w_run(int k, logic [7:0] c); return {1'b0, 5'd0, 3'd0, 16'(k), c}; endfunction
    function automatic logic [32:0] w_irq();        return {1'b0, 5'd2, 27'd0}; endfunction
    function automatic logic [32:0] w_out(int k);   return {1'b0, 5'd3, 27'(k)}; endfunction
    function automatic logic [32:0] w_data(logic [31:0] d); return {1'b0, d}; endfunction
    localparam logic [32:0] HOLE = 33'h1_0000_0000;

    task automatic check(input string what, input logic ok, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", what, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] c, input logic h, input logic i);
        e_col[ne] = c; e_hs[ne] = h; e_irq[ne] = i; ne++;
    endtask

    // Expected trace built from the requirements for the current word list.
    task automatic build_expected(input logic pos, input int cpp);
        int idx = 0;
        logic inact = !pos;
        ne = 0;
        push(8'h00, inact, 1'b0);
        while (idx < n_ent) begin
            logic [32:0] w = ent[idx];
            idx++;
            if (w[32]) begin
                push(8'h00, inact, 1'b0);
            end else begin
                case (w[31:27])
                    5'd1: for (int j = 0; j < int'(w[15:0]) + 3; j++) push(8'h00, pos, 1'b0);
                    5'd2: for (int j = 0; j < 9; j++) push(8'h00, inact, j == 0);
                    5'd3: begin
                        logic [32:0] g = '0;
                        push(8'h00, inact, 1'b0);
                        for (int p = 0; p < int'(w[15:0]) + 2; p++) begin
                            logic [7:0] pc;
                            if (p % 4 == 0) begin g = ent[idx]; idx++; end
                            pc = g[32] ? 8'h00 : g[8*(p%4) +: 8];
                            for (int j = 0; j < cpp; j++) push(pc, inact, 1'b0);
                        end
                    end
                    default: begin
                        logic [7:0] rc = (w[31:27] == 5'd0) ? w[7:0] : 8'h00;
                        for (int j = 0; j < int'(w[23:8]) + 4; j++) push(rc, inact, 1'b0);
                    end
                endcase
            end
        end
        for (int j = 0; j < 4; j++) push(8'h00, inact, 1'b0);
    endtask

    task automatic do_reset(input logic pos, input logic [3:0] cm2);
        rst_n = 1'b0; cmd_valid = 1'b0; pos_sync = pos; cpp_m2 = cm2;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Play the word list, record every cycle and compare with the model.
    task automatic run_scen(input string tag, input logic pos, input logic [3:0] cm2);
        int idx = 0;
        int bad_c = -1, bad_h = -1, bad_i = -1;
        do_reset(pos, cm2);
        build_expected(pos, int'(cm2) + 2);
        for (int c = 0; c < ne; c++) begin
            logic hs;
            @(negedge clk);
            cmd_valid = (idx < n_ent) && !ent[idx][32];
            cmd_data  = (idx < n_ent) ? ent[idx][31:0] : 32'h0;
            #1;
            a_col[c] = colour; a_hs[c] = hsync; a_irq[c] = irq;
            hs = cmd_ready && (idx < n_ent);
            @(posedge clk);
            if (hs) idx++;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c < ne; c++) begin
            if (bad_c < 0 && a_col[c] !== e_col[c]) bad_c = c;
            if (bad_h < 0 && a_hs[c]  !== e_hs[c])  bad_h = c;
            if (bad_i < 0 && a_irq[c] !== e_irq[c]) bad_i = c;
        end
        check({tag, " colour trace"}, bad_c < 0,
              bad_c < 0 ? 0 : {24'h0, a_col[bad_c]}, bad_c < 0 ? 0 : {24'h0, e_col[bad_c]});
        check({tag, " hsync trace"}, bad_h < 0,
              bad_h < 0 ? 0 : {31'h0, a_hs[bad_h]}, bad_h < 0 ? 0 : {31'h0, e_hs[bad_h]});
        check({tag, " irq trace"}, bad_i < 0,
              bad_i < 0 ? 0 : {31'h0, a_irq[bad_i]}, bad_i < 0 ? 0 : {31'h0, e_irq[bad_i]});
        check({tag, " words consumed"}, idx == n_ent, idx, n_ent);
    endtask

    // R11: idle state after reset.
    task automatic t_reset();
        do_reset(1'b1, 4'd0);
        @(negedge clk);
        check("R11 ready after reset", cmd_ready === 1'b1, {31'h0, cmd_ready}, 1);
        check("R11 colour after reset", colour === 8'h00, {24'h0, colour}, 0);
        check("R11 hsync after reset", hsync === 1'b0, {31'h0, hsync}, 0);
        check("R11 irq after reset", irq === 1'b0, {31'h0, irq}, 0);
    endtask

    // R2 R3 R4 R5 R6 R8 R12: full line, 8 pixels ending on a word boundary.
    task automatic t_full_line();
        ent[0] = w_sync(1);
        ent[1] = w_run(2, 8'h00);
        ent[2] = w_irq();
        ent[3] = w_out(6);
        ent[4] = w_data(32'h44332211);
        ent[5] = w_data(32'h88776655);
        ent[6] = w_run(0, 8'h5A);
        n_ent = 7;
        run_scen("R2 R3 R4 R5 R6 R8 R12 full line", 1'b1, 4'd0);
    endtask

    // R7 R5 R6: negative sync, 3 clocks per pixel, spare bytes dropped.
    task automatic t_neg_sync();
        ent[0] = w_sync(0);
        ent[1] = w_out(4);
        ent[2] = w_data(32'hA4A3A2A1);
        ent[3] = w_data(32'hFFEEB6B5);
        ent[4] = w_run(1, 8'h33);
        n_ent = 5;
        run_scen("R7 R5 R6 negative sync", 1'b0, 4'd1);
    endtask

    // R1: unknown code acts as a black run.
    task automatic t_unknown();
        ent[0] = {1'b0, 5'h1F, 3'd0, 16'd3, 8'hAB};
        ent[1] = w_run(1, 8'hC3);
        ent[2] = {1'b0, 5'h09, 3'd0, 16'd0, 8'h77};
        n_ent = 3;
        run_scen("R1 unknown code", 1'b1, 4'd0);
    endtask

    // R10: missing data word in the middle group of a ten-pixel run.
    task automatic t_underrun();
        ent[0] = w_out(8);
        ent[1] = w_data(32'h14131211);
        ent[2] = HOLE;
        ent[3] = w_data(32'h00003231);
        ent[4] = w_run(0, 8'h9C);
        n_ent = 5;
        run_scen("R10 pixel underrun", 1'b1, 4'd0);
    endtask

    // R9: missing command word gives an idle cycle.
    task automatic t_gap();
        ent[0] = w_sync(2);
        ent[1] = HOLE;
        ent[2] = HOLE;
        ent[3] = w_run(1, 8'h21);
        ent[4] = w_irq();
        n_ent = 5;
        run_scen("R9 command gap", 1'b1, 4'd0);
    endtask

    initial begin
        t_reset();
        t_full_line();
        t_neg_sync();
        t_unknown();
        t_underrun();
        t_gap();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule